// File: doc/BRIEF.md
# NAND Flash Page-Access Sequencer

This block turns a one-beat host request into the full bus sequence of an 8-bit asynchronous NAND flash device. The device bus has chip enable, command latch, address latch, write strobe, read strobe, separate data-out/data-in byte lanes with an output enable, and an open ready/busy line. A request names the operation (page program or page read), a four-byte start address, a byte count and a chip-enable mode. Data then flows through two valid/ready byte streams: one toward the flash for programming and one out of it for reading.

A program runs the setup command 80h, four address cycles, the data bytes, and the confirm command 10h. It then waits until the device has gone busy and back to ready. A read runs command 00h and four address cycles, then waits out the array-read busy time, then strobes the bytes out one by one. Every setup, strobe, hold and access window is a whole number of system clocks set by parameters.

In power-saving mode chip enable is dropped between individual data bytes. Each byte then gets a fresh chip-enable setup margin and a chip-enable-to-data access margin. Chip enable stays low through command cycles, through address cycles and through the whole read busy period. The ready/busy line is synchronized before use. It is only looked at after a fixed wait that is longer than the device's strobe-to-busy latency.

Byte counts of 0 are treated as 1, and counts above the page size are cut to the page size.

Back-pressure works as follows:
- On the write stream, a byte moves when `wr_valid` and `wr_ready` are both high at a rising clock edge. The bus stalls for as long as the host withholds data.
- On the read stream, `rd_valid` and `rd_data` hold steady until `rd_ready` takes the byte. No new read strobe starts while a byte is pending.

Top module: `nand_page_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive). Command latch, address latch, data output enable and `done` are low, and `req_ready` is high.
- R2: A program request produces latched bytes in this order: command 80h (CLE=1, ALE=0), then four address bytes (ALE=1, CLE=0) in the order addr[7:0], addr[15:8], addr[23:16], addr[31:24], then the requested data bytes in stream order (CLE=0, ALE=0), then command 10h. Every byte is taken by the device on the rising edge of the write strobe.
- R3: `done` after a program is a single-cycle pulse. It is raised only once 10h has been latched and ready/busy has gone low and returned high.
- R4: A read request latches command 00h and the four address bytes in the R2 order, waits for ready/busy to return high, and then issues exactly the requested number of read strobes. The bytes appear on the read stream in order. `done` pulses once after the last byte is captured.
- R5: Chip enable is low throughout every command and address cycle. After the last read address byte it stays low continuously until ready/busy has returned high.
- R6: With `req_ce_save`=1, chip enable rises between every two consecutive data bytes. With `req_ce_save`=0 it stays low from the first data strobe to the last.
- R7: Each write strobe stays low for at least T_WP clocks and has chip enable low for at least T_CS clocks before it falls. The output byte is driven and stable while the strobe is low and for T_CH clocks after it rises.
- R8: A read byte is captured no earlier than T_REA clocks after the read strobe falls and no earlier than T_CEA clocks after chip enable falls.
- R9: A request is accepted only when the sequencer is idle with no read byte pending. A request offered while an operation runs puts nothing on the bus.
- R10: A data-load cycle starts only on a write-stream handshake, so gaps in `wr_valid` lose no byte. While `rd_valid`=1 and `rd_ready`=0, no read strobe starts and `rd_data` holds.
- R11: The command latch and the address latch are never high together, and the write strobe and the read strobe are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted (idle, no pending read byte) |
| req_write | input | 1 | 1 = page program, 0 = page read |
| req_ce_save | input | 1 | 1 = release chip enable between data bytes |
| req_addr | input | 32 | Start address, sent low byte first |
| req_len | input | LEN_W (10) | Data byte count |
| wr_valid | input | 1 | Write-stream byte valid |
| wr_ready | output | 1 | Write-stream byte accepted |
| wr_data | input | 8 | Write-stream byte |
| rd_valid | output | 1 | Read-stream byte valid |
| rd_ready | input | 1 | Read-stream byte taken |
| rd_data | output | 8 | Read-stream byte |
| done | output | 1 | One-cycle operation-complete pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven to the device |
| nand_io_oe | output | 1 | Drive enable for nand_io_out |
| nand_io_in | input | 8 | Byte returned by the device |
| nand_rb | input | 1 | Ready (1) / busy (0), asynchronous |

## Verification
The bench builds the block with T_CS=2, T_WP=2, T_CH=1, T_REA=2, T_WB=6 and the page size at its full 528 bytes. T_CEA is raised to 6. In power-saving reads, the chip-enable access margin therefore outlasts the strobe access time, so the capture point is set by the chip-enable rule rather than by the strobe. A device model returns a junk byte until both margins are met, which makes a capture one clock too early visible in the data. The full page size lets one program move all 528 data bytes through the counters.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {K_CMD, K_ADDR, K_DIN, K_DOUT} cyc_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_DIN, S_CMD2, S_BUSYDLY, S_WAITRB, S_DOUT, S_DONE
  } seq_state_e;

  localparam logic [7:0] OP_PROG_SETUP   = 8'h80;
  localparam logic [7:0] OP_PROG_CONFIRM = 8'h10;
  localparam logic [7:0] OP_READ_SETUP   = 8'h00;
  localparam int         ADDR_CYCLES     = 4;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], async_i};
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_seq_pkg::*;
#(
  parameter int T_CS  = 2,
  parameter int T_WP  = 2,
  parameter int T_CH  = 1,
  parameter int T_REA = 2,
  parameter int T_CEA = 4,
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  cyc_kind_e  kind_i,
  input  logic [7:0] byte_i,
  input  logic       ce_low_i,
  input  logic [7:0] io_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_n_o,
  output logic       re_n_o,
  output logic [7:0] io_o,
  output logic       io_oe_o
);
  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_STROBE, E_HOLD} phase_e;

  localparam logic [CNT_W-1:0] L_CS  = CNT_W'(T_CS - 1);
  localparam logic [CNT_W-1:0] L_WP  = CNT_W'(T_WP - 1);
  localparam logic [CNT_W-1:0] L_CH  = CNT_W'(T_CH - 1);
  localparam logic [CNT_W-1:0] L_REA = CNT_W'(T_REA - 1);
  localparam logic [CNT_W-1:0] L_CEA = CNT_W'(T_CEA - 1);
  localparam logic [CNT_W-1:0] CEA_SAT = CNT_W'(T_CEA);

  phase_e           ph;
  cyc_kind_e        kind_q;
  logic [7:0]       byte_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ce_age;
  logic             active, is_wr, rd_ok;

  assign active = (ph != E_IDLE);
  assign is_wr  = (kind_q != K_DOUT);
  assign rd_ok  = (cnt >= L_REA) && (ce_age >= L_CEA);

  // clocks since chip enable last fell, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ce_age <= '0;
    else if (!ce_low_i)         ce_age <= '0;
    else if (ce_age != CEA_SAT) ce_age <= ce_age + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= E_IDLE;
      kind_q  <= K_CMD;
      byte_q  <= '0;
      cnt     <= '0;
      rdata_o <= '0;
    end else begin
      case (ph)
        E_IDLE: if (start_i) begin
          ph     <= E_SETUP;
          kind_q <= kind_i;
          byte_q <= byte_i;
          cnt    <= '0;
        end
        E_SETUP: begin
          if (cnt == L_CS) begin ph <= E_STROBE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        E_STROBE: begin
          if (is_wr) begin
            if (cnt == L_WP) begin ph <= E_HOLD; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end else if (rd_ok) begin
            rdata_o <= io_i;
            ph      <= E_HOLD;
            cnt     <= '0;
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
        E_HOLD: begin
          if (cnt == L_CH) ph <= E_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: ph <= E_IDLE;
      endcase
    end
  end

  assign done_o  = (ph == E_HOLD) && (cnt == L_CH);
  assign busy_o  = active;
  assign cle_o   = active && (kind_q == K_CMD);
  assign ale_o   = active && (kind_q == K_ADDR);
  assign we_n_o  = !((ph == E_STROBE) && is_wr);
  assign re_n_o  = !((ph == E_STROBE) && !is_wr);
  assign io_o    = byte_q;
  assign io_oe_o = active && is_wr;
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int T_CS  = 2,
  parameter int T_WP  = 2,
  parameter int T_CH  = 1,
  parameter int T_REA = 2,
  parameter int T_CEA = 4,
  parameter int T_WB  = 6,
  parameter int CNT_W = 8,
  localparam int ADDR_W = 8 * ADDR_CYCLES,
  localparam int LEN_W  = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_ce_save,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_in,
  input  logic              nand_rb
);
  localparam int WB_W = $clog2(T_WB + 1);
  localparam logic [LEN_W-1:0] LAST_ADDR = LEN_W'(ADDR_CYCLES - 1);
  localparam logic [LEN_W-1:0] PAGE_MAX  = LEN_W'(PAGE_BYTES);
  localparam logic [WB_W-1:0]  WB_LAST   = WB_W'(T_WB - 1);

  seq_state_e        state;
  logic              op_write, save_q, launched;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q, idx, len_eff;
  logic [WB_W-1:0]   wait_cnt;
  logic              rb_s, ce_hold, tr_window;
  logic              eng_start, eng_busy, eng_done;
  cyc_kind_e         eng_kind;
  logic [7:0]        eng_byte, eng_rdata;

  nand_rb_sync #(.STAGES(2)) i_rb_sync (
    .clk(clk), .rst_n(rst_n), .async_i(nand_rb), .sync_o(rb_s)
  );

  nand_bus_cycle #(
    .T_CS(T_CS), .T_WP(T_WP), .T_CH(T_CH), .T_REA(T_REA), .T_CEA(T_CEA), .CNT_W(CNT_W)
  ) i_cycle (
    .clk(clk), .rst_n(rst_n), .start_i(eng_start), .kind_i(eng_kind), .byte_i(eng_byte),
    .ce_low_i(!nand_ce_n), .io_i(nand_io_in), .busy_o(eng_busy), .done_o(eng_done),
    .rdata_o(eng_rdata), .cle_o(nand_cle), .ale_o(nand_ale), .we_n_o(nand_we_n),
    .re_n_o(nand_re_n), .io_o(nand_io_out), .io_oe_o(nand_io_oe)
  );

  assign len_eff = (req_len == '0) ? LEN_W'(1) :
                   (req_len > PAGE_MAX) ? PAGE_MAX : req_len;

  assign req_ready = (state == S_IDLE) && !rd_valid;
  assign wr_ready  = (state == S_DIN) && !launched;
  assign done      = (state == S_DONE);
  assign tr_window = (state == S_BUSYDLY) || (state == S_WAITRB);

  // which bus cycle to launch in the current state
  always_comb begin
    eng_start = 1'b0;
    eng_kind  = K_CMD;
    eng_byte  = addr_q[7:0];
    case (state)
      S_CMD1: begin
        eng_start = !launched;
        eng_byte  = op_write ? OP_PROG_SETUP : OP_READ_SETUP;
      end
      S_ADDR: begin
        eng_start = !launched;
        eng_kind  = K_ADDR;
      end
      S_DIN: begin
        eng_start = !launched && wr_valid;
        eng_kind  = K_DIN;
        eng_byte  = wr_data;
      end
      S_CMD2: begin
        eng_start = !launched;
        eng_byte  = OP_PROG_CONFIRM;
      end
      S_DOUT: begin
        eng_start = !launched && !rd_valid;
        eng_kind  = K_DOUT;
      end
      default: ;
    endcase
  end

  // chip enable held by the sequencer outside engine activity
  always_comb begin
    case (state)
      S_CMD1, S_ADDR, S_CMD2, S_BUSYDLY, S_WAITRB: ce_hold = 1'b1;
      S_DIN, S_DOUT:                               ce_hold = !save_q;
      default:                                     ce_hold = 1'b0;
    endcase
  end
  assign nand_ce_n = !(ce_hold || eng_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_write <= 1'b0;
      save_q   <= 1'b0;
      addr_q   <= '0;
      len_q    <= LEN_W'(1);
      idx      <= '0;
      wait_cnt <= '0;
      launched <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (eng_done)       launched <= 1'b0;
      else if (eng_start) launched <= 1'b1;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;

      case (state)
        S_IDLE: if (req_valid && req_ready) begin
          op_write <= req_write;
          save_q   <= req_ce_save;
          addr_q   <= req_addr;
          len_q    <= len_eff;
          idx      <= '0;
          state    <= S_CMD1;
        end
        S_CMD1: if (eng_done) state <= S_ADDR;
        S_ADDR: if (eng_done) begin
          addr_q <= {8'h00, addr_q[ADDR_W-1:8]};
          if (idx == LAST_ADDR) begin
            idx      <= '0;
            wait_cnt <= '0;
            state    <= op_write ? S_DIN : S_BUSYDLY;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_DIN: if (eng_done) begin
          if (idx == len_q - 1'b1) state <= S_CMD2;
          else idx <= idx + 1'b1;
        end
        S_CMD2: if (eng_done) begin
          wait_cnt <= '0;
          state    <= S_BUSYDLY;
        end
        S_BUSYDLY: begin
          if (wait_cnt == WB_LAST) state <= S_WAITRB;
          else wait_cnt <= wait_cnt + 1'b1;
        end
        S_WAITRB: if (rb_s) begin
          idx   <= '0;
          state <= op_write ? S_DONE : S_DOUT;
        end
        S_DOUT: if (eng_done) begin
          rd_data  <= eng_rdata;
          rd_valid <= 1'b1;
          if (idx == len_q - 1'b1) state <= S_DONE;
          else idx <= idx + 1'b1;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_page_seq_chk.sv
module nand_page_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic [7:0] nand_io_out,
  input logic       nand_io_oe,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       tr_window,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R11
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R11
  AST_STROBE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R7
  AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_io_oe); // R7
  AST_WE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && !$past(nand_we_n)) |-> $stable(nand_io_out)); // R7
  AST_TR_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tr_window |-> !nand_ce_n); // R5
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R10
endmodule

bind nand_page_seq nand_page_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .req_valid(req_valid),
  .req_ready(req_ready), .done(done), .tr_window(tr_window),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/test_nand_page_seq.sv
module test_nand_page_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE  = 528;
  localparam int T_CS  = 2;
  localparam int T_WP  = 2;
  localparam int T_CH  = 1;
  localparam int T_REA = 2;
  localparam int T_CEA = 6;
  localparam int T_WB  = 6;
  localparam int BUSY_LAT = 2;
  localparam int T_BUSY   = 20;
  localparam int LEN_W = $clog2(PAGE + 1);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_ce_save = 0;
  logic [31:0] req_addr = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic wr_valid = 0, rd_ready = 0;
  logic [7:0] wr_data = 0;
  logic req_ready, wr_ready, rd_valid, done;
  logic [7:0] rd_data;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0] nand_io_out;
  logic [7:0] nand_io_in = 8'hEE;
  logic nand_rb = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_page_seq #(
    .PAGE_BYTES(PAGE), .T_CS(T_CS), .T_WP(T_WP), .T_CH(T_CH),
    .T_REA(T_REA), .T_CEA(T_CEA), .T_WB(T_WB), .CNT_W(8)
  ) i_nand_page_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_ce_save(req_ce_save), .req_addr(req_addr),
    .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .done(done),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb)
  );

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [1:0] log_k [0:1023];   // 1 = command, 2 = address, 0 = data
  logic [7:0] log_v [0:1023];
  int n_log = 0;
  int ce_low_cnt = 0, re_low_cnt = 0, we_low_cnt = 0, hold_left = 0;
  int tim_err = 0, excl_err = 0, ce_breach = 0;
  int ce_rises = 0, snap_first = 0, snap_last = 0, re_falls = 0;
  bit snap_any = 0, read_busy = 0;
  bit we_prev = 1, re_prev = 1, ce_prev = 1;
  logic we_cle = 0, we_ale = 0;
  logic [7:0] we_byte = 0, m_cmd = 8'hFF, rd_base = 0;
  int m_addr_n = 0, rd_index = 0, bz_delay = 0, bz_left = 0;

  function automatic logic [7:0] rd_pattern(input logic [7:0] base, input int i);
    return base ^ 8'(i) ^ 8'hA5;
  endfunction

  task automatic data_snap();
    if (!snap_any) begin snap_first = ce_rises; snap_any = 1; end
    snap_last = ce_rises;
  endtask

  task automatic model_latch(input logic c, input logic a, input logic [7:0] v);
    if (n_log < 1024) begin
      log_k[n_log] = c ? 2'd1 : (a ? 2'd2 : 2'd0);
      log_v[n_log] = v;
      n_log++;
    end
    if (c) begin
      m_cmd = v; m_addr_n = 0;
      if (v == 8'h10) bz_delay = BUSY_LAT;
    end else if (a) begin
      if (m_addr_n == 0) rd_base = v;
      m_addr_n++;
      if (m_cmd == 8'h00 && m_addr_n == 4) begin
        bz_delay = BUSY_LAT; read_busy = 1; rd_index = 0;
      end
    end else begin
      data_snap();
    end
  endtask

  always @(negedge clk) begin
    if (nand_ce_n && !ce_prev) ce_rises++;
    ce_low_cnt = nand_ce_n ? 0 : ce_low_cnt + 1;
    re_low_cnt = nand_re_n ? 0 : re_low_cnt + 1;
    if (nand_cle && nand_ale) excl_err++;
    if (!nand_we_n && !nand_re_n) excl_err++;
    if (read_busy && nand_ce_n) ce_breach++;
    if (hold_left > 0) begin
      if (!nand_io_oe || nand_io_out != we_byte) tim_err++;
      hold_left--;
    end
    if (!nand_we_n) begin
      if (nand_ce_n) tim_err++;
      if (we_prev) begin
        if (ce_low_cnt < T_CS + 1) tim_err++;
        we_byte = nand_io_out; we_cle = nand_cle; we_ale = nand_ale;
      end else if (nand_io_out != we_byte) tim_err++;
      if (!nand_io_oe) tim_err++;
      we_low_cnt++;
    end else if (!we_prev) begin
      if (we_low_cnt < T_WP) tim_err++;
      model_latch(we_cle, we_ale, we_byte);
      we_low_cnt = 0;
      hold_left = T_CH - 1;
    end
    if (!nand_re_n) begin
      if (nand_ce_n) tim_err++;
      if (re_prev) re_falls++;
      nand_io_in = (re_low_cnt >= T_REA && ce_low_cnt >= T_CEA) ?
                   rd_pattern(rd_base, rd_index) : 8'hEE;
    end else begin
      if (!re_prev) begin rd_index++; data_snap(); end
      nand_io_in = 8'hEE;
    end
    if (bz_delay > 0) begin
      bz_delay--;
      if (bz_delay == 0) begin nand_rb = 0; bz_left = T_BUSY; end
    end else if (bz_left > 0) begin
      bz_left--;
      if (bz_left == 0) begin nand_rb = 1; read_busy = 0; end
    end
    we_prev = nand_we_n; re_prev = nand_re_n; ce_prev = nand_ce_n;
  end

  // done monitor
  int done_cnt = 0, done_nlog = 0;
  logic done_rb = 0;
  bit done_busy = 0;
  always @(posedge clk) if (done) begin
    done_cnt++; done_rb = nand_rb; done_nlog = n_log;
    done_busy = (bz_delay > 0) || (bz_left > 0);
  end

  // watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  logic [7:0] wbuf [0:PAGE-1];

  task automatic issue_req(input bit wr, input bit save, input logic [31:0] a, input int len);
    @(negedge clk);
    req_write = wr; req_ce_save = save; req_addr = a; req_len = LEN_W'(len); req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R9", "req_ready after accept", int'(req_ready), 0);
  endtask

  task automatic wait_done(input int d0, input string req);
    int g = 0;
    while (done_cnt == d0 && g < 20000) begin @(negedge clk); g++; end
    check(done_cnt == d0 + 1, req, "done pulse count", done_cnt - d0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_header(input int base, input logic [7:0] cmd,
                              input logic [31:0] a, input string req);
    int errs = 0;
    if (log_k[base] != 2'd1 || log_v[base] != cmd) errs++;
    for (int k = 0; k < 4; k++)
      if (log_k[base+1+k] != 2'd2 || log_v[base+1+k] != a[8*k +: 8]) errs++;
    check(errs == 0, req, "command/address bytes wrong", errs, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(nand_ce_n == 1, "R1", "ce_n at reset", int'(nand_ce_n), 1);
    check(nand_we_n == 1 && nand_re_n == 1, "R1", "strobes at reset",
          int'({nand_we_n, nand_re_n}), 3);
    check(nand_cle == 0 && nand_ale == 0 && nand_io_oe == 0, "R1", "latch/oe at reset",
          int'({nand_cle, nand_ale, nand_io_oe}), 0);
    check(req_ready == 1 && done == 0, "R1", "ready/done at reset",
          int'({req_ready, done}), 2);
  endtask

  task automatic t_program(input logic [31:0] a, input int len, input bit save, input bit gaps);
    int base, e0, d0, i, errs, rej;
    bit gapped;
    base = n_log; e0 = tim_err; d0 = done_cnt; snap_any = 0;
    for (int k = 0; k < len; k++) wbuf[k] = 8'(k * 3) + a[7:0] + 8'd1;
    issue_req(1, save, a, len);
    i = 0; gapped = 0;
    while (i < len) begin
      @(negedge clk);
      if (gaps && (i % 3 == 1) && !gapped) begin
        wr_valid = 0; gapped = 1;
        repeat (4) @(negedge clk);
        continue;
      end
      wr_valid = 1; wr_data = wbuf[i];
      #1;
      if (wr_ready) begin
        @(posedge clk);
        i++; gapped = 0;
        #1 wr_valid = 0;
      end
    end
    wr_valid = 0;
    // a request offered mid-operation must be ignored
    @(negedge clk);
    req_write = 0; req_valid = 1; rej = 0;
    repeat (10) begin @(negedge clk); if (req_ready) rej++; end
    req_valid = 0;
    check(rej == 0, "R9", "req_ready while busy", rej, 0);
    wait_done(d0, "R3");
    check(done_rb == 1 && !done_busy, "R3", "done before ready returned",
          int'(done_busy), 0);
    check(done_nlog == base + len + 6, "R3", "bytes latched at done", done_nlog - base, len + 6);
    check(n_log == base + len + 6, "R9", "extra bus bytes after ignored request",
          n_log - base, len + 6);
    check_header(base, 8'h80, a, "R2");
    errs = 0;
    for (int k = 0; k < len; k++)
      if (log_k[base+5+k] != 2'd0 || log_v[base+5+k] != wbuf[k]) errs++;
    check(errs == 0, gaps ? "R10" : "R2", "data bytes wrong", errs, 0);
    check(log_k[base+5+len] == 2'd1 && log_v[base+5+len] == 8'h10, "R2", "confirm byte",
          int'(log_v[base+5+len]), 16);
    check(tim_err == e0, "R7", "write timing violations", tim_err - e0, 0);
    check(snap_last - snap_first == (save ? len - 1 : 0), "R6", "CE rises in data phase",
          snap_last - snap_first, save ? len - 1 : 0);
  endtask

  task automatic t_read(input logic [31:0] a, input int len, input bit save, input bit stall);
    int base, e0, d0, b0, got, g, errs, rf0;
    bit stall_done;
    logic [7:0] held;
    base = n_log; e0 = tim_err; d0 = done_cnt; b0 = ce_breach; snap_any = 0;
    issue_req(0, save, a, len);
    got = 0; g = 0; errs = 0; stall_done = 0;
    while (got < len && g < 20000) begin
      @(negedge clk); g++;
      if (stall && !stall_done && got == 2 && rd_valid) begin
        rd_ready = 0; rf0 = re_falls; held = rd_data;
        repeat (12) @(negedge clk);
        check(re_falls == rf0 && rd_valid && rd_data == held, "R10",
              "read strobes during stall", re_falls - rf0, 0);
        stall_done = 1;
      end
      rd_ready = 1;
      #1;
      if (rd_valid) begin
        if (rd_data != rd_pattern(a[7:0], got)) begin
          errs++;
          $display("FAIL R8 read byte %0d: actual=%0d expected=%0d", got,
                   rd_data, rd_pattern(a[7:0], got));
        end
        got++;
      end
    end
    @(negedge clk); rd_ready = 0;
    check(got == len, "R4", "bytes delivered", got, len);
    check(errs == 0, "R4", "read byte mismatches", errs, 0);
    wait_done(d0, "R4");
    check(n_log == base + 5, "R4", "bytes latched for read", n_log - base, 5);
    check_header(base, 8'h00, a, "R4");
    check(ce_breach == b0, "R5", "CE high during array read", ce_breach - b0, 0);
    check(tim_err == e0, "R8", "read timing violations", tim_err - e0, 0);
    check(snap_last - snap_first == (save ? len - 1 : 0), "R6", "CE rises in data phase",
          snap_last - snap_first, save ? len - 1 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_program(32'h0003_12A7, 6, 1, 1);
    t_read(32'h0001_0455, 7, 1, 1);
    t_read(32'h0200_3412, 5, 0, 0);
    t_program(32'h0000_0000, PAGE, 0, 0);
    check(excl_err == 0, "R11", "CLE/ALE or WE/RE overlap", excl_err, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule